// File: doc/BRIEF.md
# Burst Write Data Receiver

This block sits on the receiving side of a burst write path. A single write request supplies a start address, a beat count minus one, a transfer size and a burst kind. After taking the request, the block accepts data beats over a valid/ready handshake and counts them against the requested length. It checks the final-beat marker and the strobe lanes of every beat, and stores only the strobed bytes that are legal into a small local byte-addressed memory. When the last counted beat has been taken, the block presents one response on its own channel and holds it until that response is accepted.

Only one burst is in flight at a time. A read port returns one memory word per cycle, one clock after its address is given. It lets the surrounding logic, or a testbench, see what the bursts stored.

Top module: `wrx_burst_recv`

## Requirements
- R1: A burst takes exactly `req_len + 1` accepted data beats. The response becomes valid in the cycle after the beat with that count is accepted, and not earlier.
- R2: If the final-beat marker `wr_last` is high on any beat before the counted final one, the response is SLVERR. The burst still runs to its full length.
- R3: If `wr_last` is low on the counted final beat, the response is SLVERR.
- R4: Each beat has a legal lane window. It starts at the lane given by the low address bits and ends at the top lane of the size-aligned container (`2**req_size` bytes). A strobe bit set outside this window makes the response SLVERR, and that lane is not written.
- R5: Strobe bit n, when set on an accepted beat, writes `wr_data[8n+7:8n]` to the addressed byte. Lanes whose strobe is low keep their old contents. A beat with every strobe low writes nothing but still counts toward the length.
- R6: Each burst produces exactly one response. `rsp_code` is 2'b00 (OKAY) for a clean burst and 2'b10 (SLVERR) if any error was seen. The code and `rsp_valid` stay unchanged until `rsp_ready` is sampled high.
- R7: The beat address follows `req_burst`. With 2'b00 (fixed), every beat uses the start address. With 2'b01 (incrementing), each beat steps to the next size-aligned address. With 2'b10 (wrapping), the address steps the same way but stays inside an aligned region of `(req_len+1) << req_size` bytes.
- R8: `wr_ready` is low while no request is held and while a response waits for its handshake. `req_ready` is high only when the block is idle.
- R9: In a cycle where `wr_valid` is low, `wr_data`, `wr_strb` and `wr_last` have no effect on memory, on the beat count or on the response.
- R10: After synchronous reset, `req_ready` is 1, and `wr_ready` and `rsp_valid` are 0.
- R11: `rd_data` returns the memory word selected by `rd_addr` (a word index) one clock after that address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of beats minus one |
| req_size | input | 3 | log2 of the bytes per beat |
| req_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping |
| wr_valid | input | 1 | Data beat offered |
| wr_ready | output | 1 | Block can take a beat |
| wr_data | input | DATA_W | Beat data |
| wr_strb | input | DATA_W/8 | Per-lane byte strobes |
| wr_last | input | 1 | Final-beat marker |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 2 | 00 OKAY, 10 SLVERR |
| rd_addr | input | IDX_W | Memory word index to read |
| rd_data | output | DATA_W | Registered read word |

## Verification
The assertions assume that the upstream side obeys the handshake rules: it does not drop a request or beat it has offered before ready, and it raises `rsp_ready` only to accept a response. They also assume that wrapping bursts use a beat count of 2, 4, 8 or 16. The directed stimulus raises each valid only at a falling clock edge and holds it until a rising edge on which ready was high. It uses only legal wrap lengths, and it produces strobe and marker errors on purpose, as shaped inputs, so that the protocol flow itself stays legal.

// File: rtl/wrx_pkg.sv
package wrx_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_RESP
  } state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/wrx_addr_gen.sv
// Beat address sequencer and per-beat legal lane window.
module wrx_addr_gen
  import wrx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LEN_W  = 8,
  localparam int LANE_BITS = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [2:0]            size,
  input  logic [1:0]            burst,
  input  logic [LEN_W-1:0]      len,
  input  logic                  step,
  output logic [ADDR_W-LANE_BITS-1:0] word_idx,
  output logic [LANES-1:0]      legal_lanes,
  output logic                  size_bad
);

  localparam logic [ADDR_W-1:0]  ONE_A = ADDR_W'(1);
  localparam logic [LANE_BITS:0] ONE_L = (LANE_BITS+1)'(1);

  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        size_q;
  burst_e            burst_q;
  logic [ADDR_W-1:0] wrap_mask_q;

  logic [ADDR_W-1:0] nbytes, aligned, next_incr, next_wrap, next_addr;
  logic [LANE_BITS:0] lo_lane, hi_lane;

  always_comb begin
    nbytes    = ONE_A << size_q;
    aligned   = cur_addr & ~(nbytes - ONE_A);
    next_incr = aligned + nbytes;
    next_wrap = (cur_addr & ~wrap_mask_q) | (next_incr & wrap_mask_q);
    case (burst_q)
      BURST_FIXED: next_addr = cur_addr;
      BURST_WRAP:  next_addr = next_wrap;
      default:     next_addr = next_incr;
    endcase
    size_bad = size_q > 3'(LANE_BITS);
    lo_lane  = {1'b0, cur_addr[LANE_BITS-1:0]};
    hi_lane  = {1'b0, aligned[LANE_BITS-1:0]} + nbytes[LANE_BITS:0] - ONE_L;
  end

  for (genvar n = 0; n < LANES; n++) begin : g_window
    assign legal_lanes[n] = !size_bad
                         && (lo_lane <= (LANE_BITS+1)'(n))
                         && ((LANE_BITS+1)'(n) <= hi_lane);
  end

  assign word_idx = cur_addr[ADDR_W-1:LANE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr    <= '0;
      size_q      <= '0;
      burst_q     <= BURST_INCR;
      wrap_mask_q <= '0;
    end else if (load) begin
      cur_addr    <= start_addr;
      size_q      <= size;
      burst_q     <= burst_e'(burst);
      wrap_mask_q <= ((ADDR_W'(len) + ONE_A) << size) - ONE_A;
    end else if (step) begin
      cur_addr    <= next_addr;
    end
  end

endmodule

// File: rtl/wrx_beat_track.sv
// Counts accepted beats and judges the final-beat marker.
module wrx_beat_track #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             beat,
  input  logic             last_in,
  output logic             final_beat,
  output logic             last_err
);

  logic [LEN_W-1:0] count_q;
  logic [LEN_W-1:0] len_q;

  assign final_beat = (count_q == len_q);
  // early marker or missing marker
  assign last_err   = final_beat ? !last_in : last_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      len_q   <= '0;
    end else if (load) begin
      count_q <= '0;
      len_q   <= len;
    end else if (beat) begin
      count_q <= count_q + LEN_W'(1);
    end
  end

endmodule

// File: rtl/wrx_byte_mem.sv
// One byte-wide array per lane so each maps to its own RAM column.
module wrx_byte_mem #(
  parameter int LANES = 4,
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [8*LANES-1:0] rdata
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we[i]) lane_mem[waddr] <= wdata[8*i +: 8];
    end

    always_ff @(posedge clk) begin
      q <= lane_mem[raddr];
    end

    assign rdata[8*i +: 8] = q;
  end

endmodule

// File: rtl/wrx_burst_recv.sv
module wrx_burst_recv
  import wrx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int LEN_W     = 8,
  localparam int LANES     = DATA_W / 8,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int IDX_W     = $clog2(MEM_WORDS),
  localparam int ADDR_W    = IDX_W + LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_strb,
  input  logic              wr_last,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  state_e     state_q, state_d;
  logic       req_ready_q, wr_ready_q, rsp_valid_q;
  logic [1:0] rsp_code_q;
  logic       err_q;

  logic req_fire, beat_fire, rsp_fire, done_beat;
  logic [IDX_W-1:0] word_idx;
  logic [LANES-1:0] legal_lanes, mem_we;
  logic size_bad, final_beat, last_err, strb_err, beat_err;

  assign req_fire  = req_valid && req_ready_q;
  assign beat_fire = wr_valid && wr_ready_q;
  assign rsp_fire  = rsp_valid_q && rsp_ready;
  assign done_beat = beat_fire && final_beat;

  wrx_addr_gen #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LEN_W  (LEN_W)
  ) addr_i (
    .clk         (clk),
    .rst         (rst),
    .load        (req_fire),
    .start_addr  (req_addr),
    .size        (req_size),
    .burst       (req_burst),
    .len         (req_len),
    .step        (beat_fire),
    .word_idx    (word_idx),
    .legal_lanes (legal_lanes),
    .size_bad    (size_bad)
  );

  wrx_beat_track #(
    .LEN_W (LEN_W)
  ) track_i (
    .clk        (clk),
    .rst        (rst),
    .load       (req_fire),
    .len        (req_len),
    .beat       (beat_fire),
    .last_in    (wr_last),
    .final_beat (final_beat),
    .last_err   (last_err)
  );

  assign strb_err = |(wr_strb & ~legal_lanes);
  assign beat_err = strb_err || last_err || size_bad;
  assign mem_we   = beat_fire ? (wr_strb & legal_lanes) : '0;

  wrx_byte_mem #(
    .LANES (LANES),
    .WORDS (MEM_WORDS)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (word_idx),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_fire)  state_d = ST_DATA;
      ST_DATA: if (done_beat) state_d = ST_RESP;
      ST_RESP: if (rsp_fire)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_ready_q <= 1'b1;
      wr_ready_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RESP_OKAY;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      req_ready_q <= (state_d == ST_IDLE);
      wr_ready_q  <= (state_d == ST_DATA);
      rsp_valid_q <= (state_d == ST_RESP);
      if (req_fire)                   err_q <= 1'b0;
      else if (beat_fire && beat_err) err_q <= 1'b1;
      if (done_beat)
        rsp_code_q <= (err_q || beat_err) ? RESP_SLVERR : RESP_OKAY;
    end
  end

  assign req_ready = req_ready_q;
  assign wr_ready  = wr_ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;

endmodule

// File: rtl/wrx_burst_recv_chk.sv
module wrx_burst_recv_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_code
);

  logic [LEN_W:0]   beats_seen;
  logic [LEN_W-1:0] len_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      beats_seen <= '0;
      len_cap    <= '0;
    end else if (req_valid && req_ready) begin
      beats_seen <= '0;
      len_cap    <= req_len;
    end else if (wr_valid && wr_ready) begin
      beats_seen <= beats_seen + (LEN_W+1)'(1);
    end
  end

  // R1
  beats_match_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (beats_seen == ({1'b0, len_cap} + (LEN_W+1)'(1))));

  // R8
  rsp_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!wr_ready && !req_ready));

  // R8
  data_excl_req_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !req_ready);

  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)));

  // R6
  rsp_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code == 2'b00 || rsp_code == 2'b10));

  // R6
  single_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_ready) |=> !rsp_valid);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (req_ready && !wr_ready && !rsp_valid));

endmodule

bind wrx_burst_recv wrx_burst_recv_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/wrx_burst_recv_tb_top.sv
`timescale 1ns/1ps
module wrx_burst_recv_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_burst = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic        wr_last = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_code;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wrx_burst_recv dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_strb(wr_strb), .wr_last(wr_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_req(logic [7:0] addr, logic [7:0] len, logic [2:0] size, logic [1:0] burst);
    req_addr = addr; req_len = len; req_size = size; req_burst = burst;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_beat(logic [31:0] data, logic [3:0] strb, logic last);
    wr_data = data; wr_strb = strb; wr_last = last;
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take_rsp(string tag, logic [1:0] exp, int hold);
    while (!rsp_valid) @(negedge clk);
    check({tag, " code"}, 32'(rsp_code), 32'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R6 held valid", 32'(rsp_valid), 32'd1);
      check("R6 held code", 32'(rsp_code), 32'(exp));
      check("R8 wr_ready low while response waits", 32'(wr_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R6 single response", 32'(rsp_valid), 32'd0);
    check("R8 idle again", 32'(req_ready), 32'd1);
  endtask

  task automatic read_word(logic [5:0] idx, output logic [31:0] val);
    rd_addr = idx;
    @(posedge clk);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 req_ready after reset", 32'(req_ready), 32'd1);
    check("R10 wr_ready after reset", 32'(wr_ready), 32'd0);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    wr_valid = 1'b1; wr_strb = 4'hF; wr_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    check("R8 wr_ready low with no request", 32'(wr_ready), 32'd0);
    wr_valid = 1'b0;
  endtask

  task automatic t_incr_full();
    logic [31:0] v;
    send_req(8'h10, 8'd3, 3'd2, 2'b01);
    for (int i = 0; i < 4; i++) begin
      send_beat(32'hA0A0_0000 + 32'(i), 4'hF, i == 3);
      if (i < 3) check("R1 no response mid-burst", 32'(rsp_valid), 32'd0);
    end
    check("R1 response after final beat", 32'(rsp_valid), 32'd1);
    take_rsp("R6 clean incr OKAY", 2'b00, 3);
    for (int i = 0; i < 4; i++) begin
      read_word(6'(4 + i), v);
      check("R11 R7 incr word", v, 32'hA0A0_0000 + 32'(i));
    end
  endtask

  task automatic t_partial();
    logic [31:0] v;
    send_req(8'h10, 8'd1, 3'd2, 2'b01);
    send_beat(32'hFFFF_FFFF, 4'b0000, 1'b0);
    send_beat(32'h5555_5555, 4'b0101, 1'b1);
    take_rsp("R5 partial OKAY", 2'b00, 0);
    read_word(6'd4, v);
    check("R5 zero-strobe beat writes nothing", v, 32'hA0A0_0000);
    read_word(6'd5, v);
    check("R5 masked lanes", v, 32'hA055_0055);
  endtask

  task automatic t_valid_low();
    logic [31:0] v;
    send_req(8'h10, 8'd0, 3'd2, 2'b01);
    wr_valid = 1'b0; wr_data = 32'h1234_4321; wr_strb = 4'hF; wr_last = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 no response from idle data", 32'(rsp_valid), 32'd0);
    send_beat(32'hFFFF_FFFF, 4'b0000, 1'b1);
    take_rsp("R9 OKAY", 2'b00, 0);
    read_word(6'd4, v);
    check("R9 invalid data ignored", v, 32'hA0A0_0000);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    send_req(8'h20, 8'd1, 3'd2, 2'b01);
    send_beat(32'h0, 4'hF, 1'b0);
    send_beat(32'h0, 4'hF, 1'b1);
    take_rsp("R7 fill OKAY", 2'b00, 0);
    send_req(8'h20, 8'd4, 3'd0, 2'b01);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b;
      b = 8'(8'h11 * (i + 1));
      send_beat({4{b}}, 4'(1 << (i % 4)), i == 4);
    end
    take_rsp("R7 narrow OKAY", 2'b00, 0);
    read_word(6'd8, v);
    check("R7 narrow lanes step", v, 32'h4433_2211);
    read_word(6'd9, v);
    check("R7 narrow next word", v, 32'h0000_0055);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    send_req(8'h21, 8'd0, 3'd0, 2'b01);
    send_beat(32'hEEEE_EEEE, 4'b0011, 1'b1);
    take_rsp("R4 out-of-window strobe SLVERR", 2'b10, 0);
    read_word(6'd8, v);
    check("R4 illegal lane not written", v, 32'h4433_EE11);
  endtask

  task automatic t_early_last();
    logic [31:0] v;
    send_req(8'h24, 8'd2, 3'd2, 2'b01);
    send_beat(32'hC000_0000, 4'hF, 1'b1);
    send_beat(32'hC000_0001, 4'hF, 1'b0);
    check("R2 burst continues after early marker", 32'(rsp_valid), 32'd0);
    send_beat(32'hC000_0002, 4'hF, 1'b1);
    check("R1 response after counted final", 32'(rsp_valid), 32'd1);
    take_rsp("R2 early marker SLVERR", 2'b10, 0);
    read_word(6'd11, v);
    check("R2 later beats still stored", v, 32'hC000_0002);
  endtask

  task automatic t_missing_last();
    send_req(8'h30, 8'd1, 3'd2, 2'b01);
    send_beat(32'h6000_0000, 4'hF, 1'b0);
    send_beat(32'h6000_0001, 4'hF, 1'b0);
    check("R3 response after length despite no marker", 32'(rsp_valid), 32'd1);
    take_rsp("R3 missing marker SLVERR", 2'b10, 0);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    send_req(8'h32, 8'd2, 3'd1, 2'b00);
    for (int i = 0; i < 3; i++)
      send_beat({16'hB000 + 16'(i), 16'h0}, 4'b1100, i == 2);
    take_rsp("R7 fixed OKAY", 2'b00, 0);
    read_word(6'd12, v);
    check("R7 fixed keeps address", v, 32'hB002_0000);
    read_word(6'd13, v);
    check("R7 fixed next word untouched", v, 32'h6000_0001);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    send_req(8'h18, 8'd3, 3'd2, 2'b10);
    for (int i = 0; i < 4; i++)
      send_beat(32'hE000_0000 + 32'(i), 4'hF, i == 3);
    take_rsp("R7 wrap OKAY", 2'b00, 0);
    read_word(6'd6, v); check("R7 wrap beat0", v, 32'hE000_0000);
    read_word(6'd7, v); check("R7 wrap beat1", v, 32'hE000_0001);
    read_word(6'd4, v); check("R7 wrap beat2 wrapped", v, 32'hE000_0002);
    read_word(6'd5, v); check("R7 wrap beat3", v, 32'hE000_0003);
  endtask

  task automatic t_unaligned();
    logic [31:0] v;
    send_req(8'h41, 8'd1, 3'd2, 2'b01);
    send_beat(32'h7777_7777, 4'b1110, 1'b0);
    send_beat(32'h1234_5678, 4'hF, 1'b1);
    take_rsp("R4 unaligned window OKAY", 2'b00, 0);
    read_word(6'd16, v);
    check("R4 unaligned first beat", {8'h0, v[31:8]}, 32'h0077_7777);
    read_word(6'd17, v);
    check("R7 unaligned steps to aligned", v, 32'h1234_5678);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_incr_full();
    t_partial();
    t_valid_low();
    t_narrow();
    t_illegal();
    t_early_last();
    t_missing_last();
    t_fixed();
    t_wrap();
    t_unaligned();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule